// File: doc/BRIEF.md
# NAND Prefetch and Write-Post Engine

This block sits between a host register port and the 16-bit data bus of an external NAND device. It holds a word-wide FIFO of `FIFO_BYTES` bytes (64 by default), so the host never waits on a device access. The engine runs one transfer of a programmed byte count at a time, in one of two directions. In read-prefetch mode it reads words from the device into the FIFO ahead of the host, and the host drains them through a single fixed window address. In write-post mode the host fills the FIFO through the same window, and the engine drains it to the device.

Software programs a configuration register (direction, pacing mode, enable, FIFO threshold and a stored chip-select number) and a length register. It then writes the start bit of the control register. A status word reports the bytes still to move and the FIFO level. The FIFO level is the bytes ready to read in prefetch mode and the free bytes in write-post mode. A software loop can poll that status word. Instead, a DMA engine can follow a level-driven request line that rises once the FIFO level reaches the threshold.

The device side is a plain request/acknowledge word interface with one access outstanding at a time. Command cycles, address cycles, ECC and bus timing belong to other blocks.

Top module: `nand_pf_engine`

## Requirements
- R1: After reset, the configuration register reads back with only the threshold field set, equal to `FIFO_BYTES`. The length, control and status registers read 0, and `dev_req` and `dma_req` are low.
- R2: Host addresses: 0 is configuration, 1 is length, 2 is control, 3 is status and 4 is the FIFO window. The configuration fields are: bit 0 direction (1 = write-post, 0 = read-prefetch), bit 2 DMA pacing, bit 7 enable, bits 14:8 threshold in bytes and bits 26:24 chip-select. The length field is bits 13:0. Every other bit reads 0.
- R3: Writing 1 to control bit 0 starts a transfer. The start loads the remaining count with the length rounded down to even and empties the FIFO. The engine runs while control bit 0 and the enable bit are both 1. Writing 0 to control bit 0 stops new device accesses and keeps the FIFO contents and the remaining count.
- R4: In read-prefetch mode, the engine issues a device read while it is running, the FIFO has a free word and bytes are still left to fetch. It fetches exactly the programmed length and no more.
- R5: In read-prefetch mode, a host read of the window returns FIFO words in device order in bits 15:0, and each read lowers the remaining count by 2. A read of an empty FIFO returns 0 and changes nothing.
- R6: Status bits 13:0 hold the remaining byte count. Bits 30:24 hold the FIFO level: ready bytes in read-prefetch mode and free bytes in write-post mode.
- R7: In write-post mode, a host write to the window enqueues bits 15:0 only while the engine is running, the FIFO is not full and fewer than the programmed length have been accepted. Other window writes are dropped.
- R8: In write-post mode, every queued word goes to the device in order. Each device acknowledge lowers the remaining count by 2, and no device access follows once the count is 0.
- R9: `dev_req` stays high until `dev_ack`, with `dev_we` and `dev_wdata` unchanged. Each acknowledge ends exactly one access.
- R10: `dma_req` is high exactly while the engine is running, DMA pacing is set and the FIFO level (as in R6) is at or above the threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops the window in prefetch mode) |
| host_addr | input | 3 | Host register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the cycle of the read strobe |
| dev_req | output | 1 | Device access request |
| dev_we | output | 1 | Access is a device write |
| dev_wdata | output | 16 | Word written to the device |
| dev_rdata | input | 16 | Word read from the device, valid with `dev_ack` |
| dev_ack | input | 1 | Device access complete |
| dma_req | output | 1 | Threshold-paced DMA request |

## Verification
The bench builds the engine with `FIFO_BYTES` set to 16, an eight-word FIFO. This lets transfers of a few dozen bytes fill the FIFO completely and stall the prefetch. Window writes then run into back-pressure, and the threshold test can cross the full FIFO level. The reset value of the threshold also becomes 16. A device model with adjustable latency covers both acknowledge on the next cycle and long waits with the request held.

// File: rtl/pf_pkg.sv
// pf_pkg: shared register indices, field widths and the configuration
// record of the NAND prefetch/write-post engine.
package pf_pkg;
    localparam int LEN_W = 14;   // length / remaining field width
    localparam int THR_W = 7;    // threshold and level field width
    localparam int CS_W  = 3;    // stored chip-select field width

    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_LEN  = 3'd1;
    localparam logic [2:0] A_CTRL = 3'd2;
    localparam logic [2:0] A_STAT = 3'd3;
    localparam logic [2:0] A_WIN  = 3'd4;

    typedef struct packed {
        logic [CS_W-1:0]  cs;
        logic [THR_W-1:0] thr;
        logic             en;
        logic             dma;
        logic             dir;   // 1 = write-post, 0 = read-prefetch
    } pf_cfg_t;
endpackage

// File: rtl/pf_regs.sv
// pf_regs: configuration, length and control registers.
// Assumes: one host write per cycle; start is a one-cycle pulse in the
// cycle a 1 is written to control bit 0.
module pf_regs
    import pf_pkg::*;
#(
    parameter int THR_RST = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [2:0]       host_addr,
    input  logic [31:0]      host_wdata,
    output pf_cfg_t          cfg,
    output logic [LEN_W-1:0] len,
    output logic             go,
    output logic             start
);
    logic unused_wbits;
    assign unused_wbits = ^{host_wdata[31:27], host_wdata[23:15]};

    assign start = host_wr && (host_addr == A_CTRL) && host_wdata[0];

    // Register updates from host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{cs: '0, thr: THR_W'(THR_RST), en: 1'b0, dma: 1'b0, dir: 1'b0};
            len <= '0;
            go  <= 1'b0;
        end else if (host_wr) begin
            case (host_addr)
                A_CFG: cfg <= '{cs:  host_wdata[26:24],
                                thr: host_wdata[14:8],
                                en:  host_wdata[7],
                                dma: host_wdata[2],
                                dir: host_wdata[0]};
                A_LEN:  len <= host_wdata[LEN_W-1:0];
                A_CTRL: go  <= host_wdata[0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pf_fifo.sv
// pf_fifo: word FIFO with synchronous flush, simultaneous push and pop.
// Assumes: DEPTH is a power of two; callers never push when full nor
// pop when empty. The head word is visible combinationally on dout.
module pf_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    assign dout = mem[rp];

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp] <= din;
    end
endmodule

// File: rtl/pf_seq.sv
// pf_seq: transfer sequencer. Tracks the remaining byte count and the
// bytes left to fetch (prefetch) or accept (write-post), decides FIFO
// pushes and pops, and runs the single-outstanding device handshake.
// Assumes: start is not issued while a device access is outstanding.
module pf_seq
    import pf_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             dir,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             win_rd,
    input  logic             win_wr,
    input  logic [W-1:0]     host_word,
    input  logic             fifo_empty,
    input  logic             fifo_full,
    input  logic [W-1:0]     fifo_head,
    output logic             fifo_push,
    output logic             fifo_pop,
    output logic [W-1:0]     fifo_din,
    output logic [LEN_W-1:0] remain,
    output logic             dev_req,
    output logic             dev_we,
    output logic [W-1:0]     dev_wdata,
    input  logic [W-1:0]     dev_rdata,
    input  logic             dev_ack
);
    localparam logic [LEN_W-1:0] STEP = LEN_W'(2);

    logic [LEN_W-1:0] left;
    logic host_pop, host_push, issue_rd, issue_wr, done, dev_rd_done, dev_wr_done;

    assign host_pop    = win_rd && !dir && !fifo_empty;
    assign host_push   = win_wr && dir && running && !fifo_full && (left != '0);
    assign issue_rd    = running && !dir && !dev_req && (left != '0) && !fifo_full;
    assign issue_wr    = running && dir && !dev_req && !fifo_empty;
    assign done        = dev_req && dev_ack;
    assign dev_rd_done = done && !dev_we;
    assign dev_wr_done = done && dev_we;

    assign fifo_push = host_push || dev_rd_done;
    assign fifo_pop  = host_pop || issue_wr;
    assign fifo_din  = host_push ? host_word : dev_rdata;

    // Byte counters: loaded on start, stepped by two per word moved
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            left   <= '0;
        end else if (start) begin
            remain <= {len[LEN_W-1:1], 1'b0};
            left   <= {len[LEN_W-1:1], 1'b0};
        end else begin
            if (host_pop || dev_wr_done) remain <= remain - STEP;
            if (host_push || dev_rd_done) left  <= left - STEP;
        end
    end

    // Device handshake: one access outstanding, held until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_req   <= 1'b0;
            dev_we    <= 1'b0;
            dev_wdata <= '0;
        end else if (issue_rd || issue_wr) begin
            dev_req   <= 1'b1;
            dev_we    <= issue_wr;
            dev_wdata <= fifo_head;
        end else if (done) begin
            dev_req   <= 1'b0;
        end
    end
endmodule

// File: rtl/nand_pf_engine.sv
// nand_pf_engine: byte-count-driven FIFO engine between a host register
// port and a 16-bit NAND data bus, with read-prefetch and write-post
// directions, a status word and a threshold-paced DMA request.
// Assumes: FIFO_BYTES is a power of two between 4 and 64.
module nand_pf_engine
    import pf_pkg::*;
#(
    parameter int FIFO_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        dev_req,
    output logic        dev_we,
    output logic [15:0] dev_wdata,
    input  logic [15:0] dev_rdata,
    input  logic        dev_ack,
    output logic        dma_req
);
    localparam int DEPTH = FIFO_BYTES / 2;
    localparam int CW    = $clog2(DEPTH) + 1;

    pf_cfg_t          cfg;
    logic [LEN_W-1:0] len, remain;
    logic             go, start, running;
    logic [CW-1:0]    fifo_cnt;
    logic [15:0]      fifo_head, fifo_din;
    logic             fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [THR_W-1:0] fill_b, free_b, level;
    logic             win_rd, win_wr;

    assign running    = go && cfg.en;
    assign fifo_empty = (fifo_cnt == '0);
    assign fifo_full  = (fifo_cnt == CW'(DEPTH));
    assign fill_b     = THR_W'({fifo_cnt, 1'b0});
    assign free_b     = THR_W'(FIFO_BYTES) - fill_b;
    assign level      = cfg.dir ? free_b : fill_b;
    assign win_rd     = host_rd && (host_addr == A_WIN);
    assign win_wr     = host_wr && (host_addr == A_WIN);
    assign dma_req    = running && cfg.dma && (level >= cfg.thr);

    pf_regs #(.THR_RST(FIFO_BYTES)) u_regs (
        .clk, .rst_n, .host_wr, .host_addr, .host_wdata,
        .cfg, .len, .go, .start
    );

    pf_fifo #(.DEPTH(DEPTH), .W(16)) u_fifo (
        .clk, .rst_n, .flush(start), .push(fifo_push), .pop(fifo_pop),
        .din(fifo_din), .dout(fifo_head), .cnt(fifo_cnt)
    );

    pf_seq #(.W(16)) u_seq (
        .clk, .rst_n, .running, .dir(cfg.dir), .start, .len,
        .win_rd, .win_wr, .host_word(host_wdata[15:0]),
        .fifo_empty, .fifo_full, .fifo_head,
        .fifo_push, .fifo_pop, .fifo_din, .remain,
        .dev_req, .dev_we, .dev_wdata, .dev_rdata, .dev_ack
    );

    // Host read-data selection
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_CFG: begin
                host_rdata[0]     = cfg.dir;
                host_rdata[2]     = cfg.dma;
                host_rdata[7]     = cfg.en;
                host_rdata[14:8]  = cfg.thr;
                host_rdata[26:24] = cfg.cs;
            end
            A_LEN:  host_rdata[LEN_W-1:0] = len;
            A_CTRL: host_rdata[0] = go;
            A_STAT: begin
                host_rdata[LEN_W-1:0] = remain;
                host_rdata[30:24]     = level;
            end
            A_WIN:  if (!cfg.dir && !fifo_empty) host_rdata[15:0] = fifo_head;
            default: ;
        endcase
    end
endmodule

// File: rtl/pf_chk.sv
// pf_chk: protocol and counter properties of nand_pf_engine, bound to it.
module pf_chk #(
    parameter int DEPTH = 32,
    parameter int CW    = 6,
    parameter int LW    = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dev_req,
    input logic          dev_ack,
    input logic          dev_we,
    input logic [15:0]   dev_wdata,
    input logic          dir,
    input logic          start,
    input logic [CW-1:0] fifo_cnt,
    input logic [LW-1:0] remain
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));                                           // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && !dev_ack) |=> (dev_req && $stable(dev_we) && $stable(dev_wdata))); // R9
    AST_REMAIN_LOADS_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (remain <= $past(remain)));                             // R3
    AST_PREFETCH_READS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && !dir) |-> !dev_we);                                    // R4
    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (remain == '0 && !dev_req && !start) |=> !dev_req);                // R8
endmodule

bind nand_pf_engine pf_chk #(.DEPTH(DEPTH), .CW(CW), .LW(pf_pkg::LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_ack(dev_ack),
    .dev_we(dev_we), .dev_wdata(dev_wdata), .dir(cfg.dir), .start(start),
    .fifo_cnt(fifo_cnt), .remain(remain)
);

// File: tb/sim_nand_pf_engine.sv
`timescale 1ns/1ps
module sim_nand_pf_engine;
    localparam int FB = 16;
    localparam logic [2:0] A_CFG = 3'd0, A_LEN = 3'd1, A_CTRL = 3'd2, A_STAT = 3'd3, A_WIN = 3'd4;
    localparam logic [31:0] DIR = 32'h1, DMA = 32'h4, EN = 32'h80;

    typedef struct packed {
        logic        dir;
        logic [13:0] len;
        logic [3:0]  lat;
    } vec_t;
    localparam vec_t VECS [6] = '{
        '{1'b0, 14'd8,  4'd0},
        '{1'b0, 14'd40, 4'd3},
        '{1'b0, 14'd7,  4'd1},
        '{1'b1, 14'd12, 4'd2},
        '{1'b1, 14'd34, 4'd0},
        '{1'b1, 14'd2,  4'd5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic dev_req, dev_we, dma_req;
    logic [15:0] dev_wdata;
    logic [15:0] dev_rdata = '0;
    logic dev_ack = 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int dev_lat = 0, lat_cnt = 0, acc_cnt = 0, rd_idx = 0, wr_idx = 0;
    logic clr = 1'b0;
    logic [15:0] rd_base = '0;
    logic [15:0] wr_log [64];

    always #10 clk = ~clk;

    nand_pf_engine #(.FIFO_BYTES(FB)) u0 (
        .clk, .rst_n, .host_wr, .host_rd, .host_addr, .host_wdata, .host_rdata,
        .dev_req, .dev_we, .dev_wdata, .dev_rdata, .dev_ack, .dma_req
    );

    // Device model: acknowledges each request after dev_lat waiting cycles
    always @(posedge clk) begin
        if (clr) begin
            acc_cnt <= 0; rd_idx <= 0; wr_idx <= 0;
        end
        if (!rst_n) begin
            dev_ack <= 1'b0; lat_cnt <= 0;
        end else if (dev_ack) begin
            dev_ack <= 1'b0;
        end else if (dev_req) begin
            if (lat_cnt >= dev_lat) begin
                dev_ack <= 1'b1; lat_cnt <= 0; acc_cnt <= acc_cnt + 1;
                if (dev_we) begin
                    if (wr_idx < 64) wr_log[wr_idx] <= dev_wdata;
                    wr_idx <= wr_idx + 1;
                end else begin
                    dev_rdata <= rd_base + 16'(rd_idx);
                    rd_idx <= rd_idx + 1;
                end
            end else lat_cnt <= lat_cnt + 1;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] a, input logic [31:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [2:0] a, output logic [31:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic clear_log();
        clr = 1'b1; @(negedge clk); clr = 1'b0;
    endtask

    // Poll status until the level field reaches at least lvl
    task automatic wait_level(input int lvl);
        logic [31:0] s;
        int guard = 0;
        hr(A_STAT, s);
        while (int'(s[30:24]) < lvl && guard < 5000) begin hr(A_STAT, s); guard++; end
    endtask

    // Poll status until the remaining field is zero
    task automatic wait_done();
        logic [31:0] s;
        int guard = 0;
        hr(A_STAT, s);
        while (s[13:0] != 0 && guard < 5000) begin hr(A_STAT, s); guard++; end
    endtask

    initial begin
        logic [31:0] d, s;
        int words, bad;
        logic [13:0] even;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 dev_req", 32'(dev_req), 0);
        chk("R1 dma_req", 32'(dma_req), 0);
        hr(A_CFG, d);  chk("R1 cfg", d, 32'(FB) << 8);
        hr(A_LEN, d);  chk("R1 len", d, 0);
        hr(A_CTRL, d); chk("R1 ctrl", d, 0);
        hr(A_STAT, d); chk("R1 status", d, 0);

        // R2: field readback
        hw(A_CFG, 32'hFFFF_FFFF); hr(A_CFG, d); chk("R2 cfg fields", d, 32'h0700_7F85);
        hw(A_LEN, 32'hFFFF_FFFF); hr(A_LEN, d); chk("R2 len field", d, 32'h0000_3FFF);
        hw(A_CFG, 32'h0000_1000); hr(A_CTRL, d); chk("R2 ctrl idle", d, 0);

        // Table of transfers, one loop
        foreach (VECS[i]) begin
            dev_lat = int'(VECS[i].lat);
            rd_base = 16'h1000 * 16'(i + 1);
            even = {VECS[i].len[13:1], 1'b0};
            words = int'(even) / 2;
            bad = 0;
            clear_log();
            hw(A_LEN, 32'(VECS[i].len));
            hw(A_CFG, (VECS[i].dir ? DIR : 32'h0) | EN | (32'(FB) << 8));
            hw(A_CTRL, 32'h1);
            if (!VECS[i].dir) begin
                for (int k = 0; k < words; k++) begin
                    wait_level(2);
                    hr(A_WIN, d);
                    if (d !== 32'(rd_base + 16'(k))) bad++;
                    if (k == 0) begin
                        hr(A_STAT, s);
                        chk("R5 remaining after first pop", 32'(s[13:0]), 32'(even) - 2);
                    end
                end
                chk("R5 prefetch data order mismatches", 32'(bad), 0);
                hr(A_STAT, s); chk("R6 remaining at end", 32'(s[13:0]), 0);
                repeat (20) @(negedge clk);
                chk("R4 device reads equal length", 32'(acc_cnt), 32'(words));
            end else begin
                for (int k = 0; k < words; k++) begin
                    wait_level(2);
                    hw(A_WIN, 32'(16'hA000 + 16'(i * 64 + k)));
                end
                wait_done();
                repeat (4) @(negedge clk);
                chk("R8 device writes equal length", 32'(wr_idx), 32'(words));
                for (int k = 0; k < words; k++)
                    if (wr_log[k] !== 16'hA000 + 16'(i * 64 + k)) bad++;
                chk("R8 drain data order mismatches", 32'(bad), 0);
                hr(A_STAT, s); chk("R6 free bytes when drained", 32'(s[30:24]), FB);
            end
            hw(A_CTRL, 32'h0);
            repeat (4) @(negedge clk);
        end

        // R5: empty window read with the engine disabled
        clear_log();
        hw(A_LEN, 32'd8); hw(A_CFG, 32'(FB) << 8); hw(A_CTRL, 32'h1);
        hr(A_WIN, d);  chk("R5 empty window read", d, 0);
        hr(A_STAT, s); chk("R5 remaining untouched", 32'(s[13:0]), 8);
        chk("R3 no access while disabled", 32'(acc_cnt), 0);
        hw(A_CTRL, 32'h0);

        // R3: stop keeps state and blocks new accesses; restart flushes
        dev_lat = 1; clear_log();
        hw(A_LEN, 32'd40); hw(A_CFG, EN | (32'(FB) << 8)); hw(A_CTRL, 32'h1);
        wait_level(FB);
        hw(A_CTRL, 32'h0);
        hr(A_WIN, d); hr(A_WIN, d);
        repeat (10) @(negedge clk);
        chk("R3 no fetch after stop", 32'(acc_cnt), FB / 2);
        chk("R3 request idle after stop", 32'(dev_req), 0);
        hr(A_STAT, s); chk("R3 remaining kept on stop", 32'(s[13:0]), 36);
        hw(A_CTRL, 32'h1);
        hr(A_STAT, s); chk("R3 restart reloads and flushes", s, 32'd40);
        hw(A_CTRL, 32'h0);
        repeat (10) @(negedge clk);

        // R7/R9: writes beyond the length are dropped; request held while waiting
        dev_lat = 30; clear_log();
        hw(A_LEN, 32'd4); hw(A_CFG, DIR | EN | (32'(FB) << 8)); hw(A_CTRL, 32'h1);
        hw(A_WIN, 32'h0000_B001); hw(A_WIN, 32'h0000_B002); hw(A_WIN, 32'h0000_B003);
        repeat (8) @(negedge clk);
        chk("R9 request held", 32'(dev_req), 1);
        chk("R9 write word stable", 32'(dev_wdata), 32'h0000_B001);
        wait_done();
        repeat (40) @(negedge clk);
        chk("R7 extra window write dropped", 32'(wr_idx), 2);
        chk("R7 last accepted word", 32'(wr_log[1]), 32'h0000_B002);
        hw(A_CTRL, 32'h0);

        // R10: threshold-paced DMA request
        dev_lat = 0; clear_log();
        hw(A_LEN, 32'd40); hw(A_CFG, EN | DMA | (32'd8 << 8)); hw(A_CTRL, 32'h1);
        chk("R10 low below threshold", 32'(dma_req), 0);
        wait_level(8);
        chk("R10 high at threshold", 32'(dma_req), 1);
        hw(A_CFG, EN | (32'd8 << 8));
        chk("R10 low without pacing", 32'(dma_req), 0);
        hw(A_CTRL, 32'h0);
        repeat (6) @(negedge clk);
        hw(A_LEN, 32'd8); hw(A_CFG, DIR | EN | DMA | (32'd8 << 8)); hw(A_CTRL, 32'h1);
        chk("R10 write-post free space", 32'(dma_req), 1);
        hw(A_CFG, DIR | EN | DMA | (32'd17 << 8));
        chk("R10 threshold above level", 32'(dma_req), 0);
        hw(A_CTRL, 32'h0);

        summary();
        $finish;
    end
endmodule